// File: doc/BRIEF.md
# 4x4 Integer Inverse Transform with Pixel Reconstruction

This block turns one 4x4 tile of signed residual coefficients back into pixels. It applies a separable integer inverse transform to the coefficients, scales the result down by 64 and adds it to a 4x4 tile of 8-bit prediction pixels. Each sum is clipped to the 8-bit range, and the reconstructed tile leaves the block one row per cycle. Each 1-D pass is built from add, subtract and halve-by-shift butterflies, so the output matches the integer arithmetic of a block-based video decoder bit for bit.

A caller presents all 16 coefficients and all 16 prediction pixels on wide parallel buses and pulses `start`. The block captures everything on that edge and then emits four row beats on consecutive cycles. `done` marks the last beat. A second mode serves tiles where only the first coefficient matters. In that mode a single rounded offset is added to every pixel, and the other fifteen coefficients are not used.

Top module: `idct4_recon`

## Requirements
- R1: While reset is asserted and after its release, `out_valid`, `done` and `out_row` are all zero until a tile is accepted.
- R2: A `start` seen at a clock edge while no tile is in progress accepts the tile. Rows 0, 1, 2 and 3 then appear on `out_valid` beats in the four cycles that follow that edge. Column c of a row sits in `out_row[8c+7:8c]`.
- R3: `done` is high for exactly one cycle, together with the row 3 beat, and `out_valid` is low in the cycle after it.
- R4: While a tile is in progress, `start` is ignored and is not queued. Changes on `coef`, `pred` or `dc_mode` after acceptance do not alter the rows of that tile.
- R5: Coefficient k (row k/4, column k%4) is taken from `coef[16k+15:16k]` as two's complement. Prediction pixel k is taken from `pred[8k+7:8k]` as an unsigned value.
- R6: Full mode (`dc_mode`=0) first adds 32 to coefficient (0,0). It then runs the 1-D pass on each row and then on each column of the result, all in 16-bit arithmetic that wraps. The 1-D pass on inputs x0..x3 computes e=x0+x2, f=x0-x2, g=(x1>>>1)-x3 and h=x1+(x3>>>1), and outputs y0=e+h, y1=f+g, y2=f-g, y3=e-h.
- R7: In full mode each transformed value is shifted right arithmetically by 6 and added to its prediction pixel. The sum is clipped to 0..255.
- R8: In DC mode (`dc_mode`=1) the offset (c0+32)>>>6 is computed without wraparound and added to all 16 prediction pixels, with clipping to 0..255. Coefficients 1..15 have no effect.
- R9: The mode is sampled together with the tile at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to accept a tile |
| dc_mode | input | 1 | 1 selects the DC-only path |
| coef | input | 256 | 16 signed 16-bit coefficients, row-major |
| pred | input | 128 | 16 unsigned 8-bit prediction pixels, row-major |
| out_valid | output | 1 | A reconstructed row is on `out_row` |
| out_row | output | 32 | Four reconstructed pixels, column 0 in the low byte |
| done | output | 1 | Last row beat of the tile |

## Verification
The bench drives tiles with every coefficient at +32767, at -32768, and with alternating signs. It also drives tiles drawn at random over the full 16-bit range. A design that saturated, or that kept extra bits between the passes, would disagree wherever the 16-bit sums wrap. Prediction values of 0 and 255 paired with large residuals check both clip limits. A wrong limit, or a compare that treats the sum as unsigned, shows up as pixels that wrap instead of pinning. In DC mode the bench fills the other fifteen coefficients with junk and uses offsets near the rounding boundary (31, 32, -33) and at the extremes. A transform that leaked into the DC path, or a rounding that truncated or wrapped at +32767, would change pixels. Raising start mid-tile and changing the inputs after acceptance would expose a design that restarts or reads the buses live.

// File: rtl/idct4_recon.sv
module idct4_recon #(
  parameter int CW = 16,
  parameter int PW = 8,
  parameter int SH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dc_mode,
  input  logic [16*CW-1:0] coef,
  input  logic [16*PW-1:0] pred,
  output logic             out_valid,
  output logic [4*PW-1:0]  out_row,
  output logic             done
);
  localparam int SW = CW + 2;
  localparam logic signed [CW-1:0] RND  = CW'(1 << (SH - 1));
  localparam logic signed [CW:0]   RNDW = (CW+1)'(1 << (SH - 1));
  localparam logic signed [SW-1:0] PMAX = SW'((1 << PW) - 1);

  typedef logic signed [CW-1:0] sw_t;

  logic             busy, mode_q;
  logic [1:0]       row;
  logic [16*CW-1:0] coef_q;
  logic [16*PW-1:0] pred_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      row    <= '0;
      mode_q <= 1'b0;
      coef_q <= '0;
      pred_q <= '0;
    end else if (!busy && start) begin
      busy   <= 1'b1;
      row    <= '0;
      mode_q <= dc_mode;
      coef_q <= coef;
      pred_q <= pred;
    end else if (busy) begin
      row <= row + 2'd1;
      if (row == 2'd3) busy <= 1'b0;
    end
  end

  assign out_valid = busy;
  assign done      = busy && (row == 2'd3);

  function automatic logic [4*CW-1:0] bfly(input sw_t x0, input sw_t x1, input sw_t x2, input sw_t x3);
    sw_t e, f, g, h, y0, y1, y2, y3;
    e  = x0 + x2;
    f  = x0 - x2;
    g  = (x1 >>> 1) - x3;
    h  = x1 + (x3 >>> 1);
    y0 = e + h;
    y1 = f + g;
    y2 = f - g;
    y3 = e - h;
    return {y3, y2, y1, y0};
  endfunction

  sw_t a [16];
  sw_t m [16];
  sw_t o [16];

  always_comb begin
    for (int k = 0; k < 16; k++) a[k] = coef_q[k*CW +: CW];
    a[0] = a[0] + RND;
    for (int r = 0; r < 4; r++)
      {m[4*r+3], m[4*r+2], m[4*r+1], m[4*r]} = bfly(a[4*r], a[4*r+1], a[4*r+2], a[4*r+3]);
    for (int c = 0; c < 4; c++)
      {o[12+c], o[8+c], o[4+c], o[c]} = bfly(m[c], m[4+c], m[8+c], m[12+c]);
  end

  logic signed [CW:0] dc_ext, dc_sum, dcv;
  assign dc_ext = {coef_q[CW-1], coef_q[CW-1:0]};
  assign dc_sum = dc_ext + RNDW;
  assign dcv    = dc_sum >>> SH;

  always_comb begin
    out_row = '0;
    for (int c = 0; c < 4; c++) begin
      logic [3:0]            idx;
      sw_t                   osh;
      logic signed [SW-1:0]  res, s;
      idx = {row, 2'(c)};
      osh = o[idx] >>> SH;
      res = mode_q ? SW'(dcv) : SW'(osh);
      s   = res + signed'({{(SW-PW){1'b0}}, pred_q[idx*PW +: PW]});
      if (!busy)          out_row[c*PW +: PW] = '0;
      else if (s < 0)     out_row[c*PW +: PW] = '0;
      else if (s > PMAX)  out_row[c*PW +: PW] = {PW{1'b1}};
      else                out_row[c*PW +: PW] = s[PW-1:0];
    end
  end

  // R3
  done_with_beat_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> out_valid);
  // R3
  done_ends_tile_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !out_valid && !done);
  // R2
  beat_run_chk: assert property (@(posedge clk) disable iff (!rst_n) out_valid && !done |=> out_valid);
  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n) start && !out_valid |=> out_valid && !done);
  // R4
  hold_tile_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !done |=> $stable(coef_q) && $stable(pred_q) && $stable(mode_q));
endmodule

// File: tb/test_idct4_recon.sv
module test_idct4_recon;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n, start, dc_mode, out_valid, done;
  logic [255:0] coef;
  logic [127:0] pred;
  logic [31:0]  out_row;

  idct4_recon i_idct4_recon (
    .clk(clk), .rst_n(rst_n), .start(start), .dc_mode(dc_mode),
    .coef(coef), .pred(pred), .out_valid(out_valid), .out_row(out_row), .done(done)
  );

  int n_cmp = 0, n_bad = 0;
  int cf[16], pp[16], ex[16];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int w16(int v);
    logic signed [15:0] t;
    t = v[15:0];
    return int'(t);
  endfunction

  function automatic int clip8(int v);
    if (v < 0) return 0;
    if (v > 255) return 255;
    return v;
  endfunction

  task automatic model(bit dc);
    int a[16], m[16], o[16], e, f, g, h;
    if (dc) begin
      for (int k = 0; k < 16; k++) ex[k] = clip8(((cf[0] + 32) >>> 6) + pp[k]);
      return;
    end
    for (int k = 0; k < 16; k++) a[k] = w16(cf[k]);
    a[0] = w16(a[0] + 32);
    for (int r = 0; r < 4; r++) begin
      e = w16(a[4*r] + a[4*r+2]); f = w16(a[4*r] - a[4*r+2]);
      g = w16((a[4*r+1] >>> 1) - a[4*r+3]); h = w16(a[4*r+1] + (a[4*r+3] >>> 1));
      m[4*r] = w16(e + h); m[4*r+1] = w16(f + g); m[4*r+2] = w16(f - g); m[4*r+3] = w16(e - h);
    end
    for (int c = 0; c < 4; c++) begin
      e = w16(m[c] + m[8+c]); f = w16(m[c] - m[8+c]);
      g = w16((m[4+c] >>> 1) - m[12+c]); h = w16(m[4+c] + (m[12+c] >>> 1));
      o[c] = w16(e + h); o[4+c] = w16(f + g); o[8+c] = w16(f - g); o[12+c] = w16(e - h);
    end
    for (int k = 0; k < 16; k++) ex[k] = clip8((o[k] >>> 6) + pp[k]);
  endtask

  task automatic run_tile(bit dc, string req);
    model(dc);
    @(negedge clk);
    for (int k = 0; k < 16; k++) begin
      coef[16*k +: 16] = cf[k][15:0];
      pred[8*k +: 8]   = pp[k][7:0];
    end
    dc_mode = dc;
    start   = 1'b1;
    @(negedge clk);
    start   = 1'b0;
    coef    = {8{$urandom()}};
    pred    = {4{$urandom()}};
    dc_mode = ~dc;
    for (int b = 0; b < 4; b++) begin
      chk("R2 valid", 32'(out_valid), 32'd1);
      chk("R3 done", 32'(done), 32'(b == 3));
      for (int c = 0; c < 4; c++) chk(req, 32'(out_row[8*c +: 8]), 32'(ex[4*b+c]));
      start = (b == 1);
      @(negedge clk);
    end
    start = 1'b0;
    chk("R4 no queued start", 32'(out_valid), 32'd0);
    chk("R3 done low", 32'(done), 32'd0);
  endtask

  function automatic int rnd(int lo, int hi);
    return lo + int'($urandom_range(32'(hi - lo)));
  endfunction

  initial begin
    #4_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; dc_mode = 1'b0; coef = '0; pred = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", 32'(out_valid), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 row", out_row, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle", 32'(out_valid), 32'd0);

    for (int k = 0; k < 16; k++) begin cf[k] = 0; pp[k] = 16 * k; end
    run_tile(1'b0, "R6 zero");
    // R5 placement: one coefficient at row 1 column 2
    for (int k = 0; k < 16; k++) begin cf[k] = (k == 6) ? 640 : 0; pp[k] = 128; end
    run_tile(1'b0, "R5");
    for (int k = 0; k < 16; k++) begin cf[k] = (k == 0) ? 100 : 0; pp[k] = 50 + k; end
    run_tile(1'b0, "R6 dc-in-full");
    for (int t = 0; t < 20; t++) begin
      for (int k = 0; k < 16; k++) begin cf[k] = rnd(-2000, 2000); pp[k] = rnd(0, 255); end
      run_tile(1'b0, "R6 random");
    end
    // R6 wraparound extremes
    for (int k = 0; k < 16; k++) begin cf[k] = 32767; pp[k] = 100; end
    run_tile(1'b0, "R6 all max");
    for (int k = 0; k < 16; k++) begin cf[k] = -32768; pp[k] = 100; end
    run_tile(1'b0, "R6 all min");
    for (int k = 0; k < 16; k++) begin cf[k] = (k % 2) ? -32768 : 32767; pp[k] = rnd(0, 255); end
    run_tile(1'b0, "R6 alternating");
    for (int t = 0; t < 10; t++) begin
      for (int k = 0; k < 16; k++) begin cf[k] = rnd(-32768, 32767); pp[k] = rnd(0, 255); end
      run_tile(1'b0, "R6 full range");
    end
    // R7 clip limits
    for (int k = 0; k < 16; k++) begin cf[k] = (k == 0) ? 3000 : 0; pp[k] = 255; end
    run_tile(1'b0, "R7 high clip");
    for (int k = 0; k < 16; k++) begin cf[k] = (k == 0) ? -3000 : 0; pp[k] = 0; end
    run_tile(1'b0, "R7 low clip");
    for (int k = 0; k < 16; k++) begin cf[k] = 32767; pp[k] = (k % 2) ? 0 : 255; end
    run_tile(1'b0, "R7 mixed");
    // R8 DC path with junk in the other coefficients
    begin
      int dcs[8] = '{0, 31, 32, -33, 32767, -32768, 1000, -1000};
      for (int t = 0; t < 8; t++) begin
        for (int k = 0; k < 16; k++) begin
          cf[k] = (k == 0) ? dcs[t] : rnd(-32768, 32767);
          pp[k] = (t == 4) ? 255 : (t == 5) ? 0 : rnd(0, 255);
        end
        run_tile(1'b1, "R8");
      end
    end
    // R9 mode taken at acceptance, input flipped right after
    for (int k = 0; k < 16; k++) begin cf[k] = (k == 0) ? 640 : 5000; pp[k] = 20 * (k % 12); end
    run_tile(1'b1, "R9 dc");
    run_tile(1'b0, "R9 full");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule